// File: doc/BRIEF.md
# Fault and Reset Sequencer

This block decides how a power-management device reacts to its most serious events. A die over-temperature or a supply over-voltage level switches off every regulator and pulls the general purpose outputs low in the same cycle. A latched severe-fault flag then keeps them off until the condition has gone away and software has cleared the flag. A falling supply or a software reset command sends the device through a full restart. The restart passes through a shutdown that holds while the supply stays low, a one-cycle register-reset strobe, a configuration load of fixed length from non-volatile memory, and a startup delay before normal operation resumes.

Each completed restart can raise a reset-occurred flag, reported on the active-low interrupt output. Whether the flag is raised depends on a mask bit that is reloaded from the non-volatile default at the end of every configuration load. As a result, a value written to the mask over the bus before a reset cannot suppress the flag for that reset. The surrounding register file drives the clear and write strobes. The analog detectors supply the fault levels.

Top module: `fault_reset_seq`

## Requirements
- R1: While `thermal_sd` or `supply_ov` is high, `regs_off` and `gpo_low` are 1 in that same cycle, without waiting for a clock edge.
- R2: A severe fault (thermal or over-voltage) latches a flag that keeps `regs_off` and `gpo_low` at 1 and `irq_n` at 0 after the condition ends. A `sev_clr` pulse clears the flag only when neither condition is active and is ignored otherwise.
- R3: `supply_uv` high at a clock edge forces the shutdown state. The machine stays there, with `regs_off`=1 and no `reg_reset` pulse, for as long as `supply_uv` stays high.
- R4: On leaving shutdown, `reg_reset` is high for exactly one cycle. Then `otp_load` is high for exactly LOAD_CYCLES cycles, and `otp_done` is high only in the last of them. STARTUP_CYCLES cycles follow, and `regs_off` drops at the (2+LOAD_CYCLES+STARTUP_CYCLES)-th edge after the last edge spent in shutdown.
- R5: `sw_reset` at an edge while running causes shutdown at that edge, followed by the R4 sequence. `sw_reset` during shutdown, reset, load or startup has no effect.
- R6: `rst_mask` takes the value of `otp_mask_in` at the edge where `otp_done` is high. While running, `mask_wr` writes `mask_wdata` into it. A bus write made before a reset has no effect on the flag of that reset.
- R7: `rst_flag` is cleared during register reset. It is set to 1 when startup completes only if the loaded `rst_mask` is 0. While running, a `flag_clr` pulse clears it.
- R8: `irq_n` is 0 exactly when the reset-occurred flag or the severe-fault flag is set.
- R9: While `rst_n` is low: `regs_off`=1, `gpo_low`=1, `irq_n`=1, `rst_mask`=1, `reg_reset`=0, `otp_load`=0. After release, the R4 sequence runs as a power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| thermal_sd | input | 1 | Die over-temperature shutdown level |
| supply_ov | input | 1 | Supply over-voltage level |
| supply_uv | input | 1 | Supply under-voltage level |
| sw_reset | input | 1 | Software reset command |
| sev_clr | input | 1 | Write-1 clear of the severe-fault flag |
| flag_clr | input | 1 | Write-1 clear of the reset-occurred flag |
| mask_wr | input | 1 | Bus write strobe for the reset mask |
| mask_wdata | input | 1 | Bus write value for the reset mask |
| otp_mask_in | input | 1 | Non-volatile default of the reset mask |
| regs_off | output | 1 | Disable all regulators |
| gpo_low | output | 1 | Force general purpose outputs low |
| reg_reset | output | 1 | Register-reset strobe |
| otp_load | output | 1 | Configuration load in progress |
| otp_done | output | 1 | Last cycle of configuration load |
| rst_flag | output | 1 | Reset-occurred flag |
| rst_mask | output | 1 | Reset-occurred mask |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A sequencer stuck in a wrong state shows first as a wrong `regs_off` edge. The moment regulators come back is counted in whole cycles from the last shutdown edge, so one extra or missing count cycle is seen as a one-cycle shift. A mask loaded at the wrong time, or not reloaded, shows at the end of the next startup as a wrong `rst_flag` and `irq_n`. A lost severe-fault latch shows at once as `regs_off` dropping when the fault level falls and before any clear is written.

// File: rtl/fault_reset_seq.sv
module fault_reset_seq #(
  parameter int LOAD_CYCLES    = 4,
  parameter int STARTUP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic thermal_sd,
  input  logic supply_ov,
  input  logic supply_uv,
  input  logic sw_reset,
  input  logic sev_clr,
  input  logic flag_clr,
  input  logic mask_wr,
  input  logic mask_wdata,
  input  logic otp_mask_in,
  output logic regs_off,
  output logic gpo_low,
  output logic reg_reset,
  output logic otp_load,
  output logic otp_done,
  output logic rst_flag,
  output logic rst_mask,
  output logic irq_n
);

  localparam int MAXC = (LOAD_CYCLES > STARTUP_CYCLES) ? LOAD_CYCLES : STARTUP_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_RUN, S_SHUTDOWN, S_RESET_REGS, S_LOAD_CFG, S_STARTUP} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          sev_flag;

  wire sev_now      = thermal_sd | supply_ov;
  wire running      = (state == S_RUN);
  wire startup_done = (state == S_STARTUP) && (cnt == CW'(STARTUP_CYCLES - 1)) && !supply_uv;

  assign otp_load  = (state == S_LOAD_CFG);
  assign otp_done  = otp_load && (cnt == CW'(LOAD_CYCLES - 1));
  assign reg_reset = (state == S_RESET_REGS);
  assign regs_off  = !running | sev_flag | sev_now;
  assign gpo_low   = regs_off;
  assign irq_n     = !(rst_flag | sev_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_SHUTDOWN;
      cnt   <= '0;
    end else if (supply_uv) begin
      state <= S_SHUTDOWN;
      cnt   <= '0;
    end else begin
      case (state)
        S_RUN:        if (sw_reset) state <= S_SHUTDOWN;
        S_SHUTDOWN:   state <= S_RESET_REGS;
        S_RESET_REGS: begin state <= S_LOAD_CFG; cnt <= '0; end
        S_LOAD_CFG:
          if (otp_done) begin state <= S_STARTUP; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_STARTUP:
          if (startup_done) begin state <= S_RUN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default:      state <= S_SHUTDOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sev_flag <= 1'b0;
      rst_flag <= 1'b0;
      rst_mask <= 1'b1;
    end else begin
      if (reg_reset)    sev_flag <= sev_now;
      else if (sev_now) sev_flag <= 1'b1;
      else if (sev_clr) sev_flag <= 1'b0;

      if (otp_done)                  rst_mask <= otp_mask_in;
      else if (running && mask_wr)   rst_mask <= mask_wdata;

      if (reg_reset)                 rst_flag <= 1'b0;
      else if (startup_done)         rst_flag <= !rst_mask;
      else if (running && flag_clr)  rst_flag <= 1'b0;
    end
  end

  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sev_now |=> !irq_n && regs_off);
  a_r3_uv_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    supply_uv |=> (state == S_SHUTDOWN) && !reg_reset);
  a_r4_reset_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reset |=> otp_load && !reg_reset);
  a_r4_load_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_done && !supply_uv) |=> (state == S_STARTUP) && !otp_load);
  a_r6_mask_from_otp: assert property (@(posedge clk) disable iff (!rst_n)
    otp_done |=> rst_mask == $past(otp_mask_in));
  a_r7_flag_at_startup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_flag) |-> $past(state) == S_STARTUP && !rst_mask);
  a_r5_sw_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sw_reset) |=> regs_off);

endmodule

// File: tb/fault_reset_seq_bench.sv
`timescale 1ns/1ps
module fault_reset_seq_bench;
  localparam int L = 4;
  localparam int S = 3;
  localparam int SEQ = 2 + L + S;

  logic clk = 0, rst_n = 0;
  logic thermal_sd = 0, supply_ov = 0, supply_uv = 0, sw_reset = 0;
  logic sev_clr = 0, flag_clr = 0, mask_wr = 0, mask_wdata = 0, otp_mask_in = 0;
  logic regs_off, gpo_low, reg_reset, otp_load, otp_done, rst_flag, rst_mask, irq_n;

  int checks = 0, errors = 0;
  int n_edges, n_rr, n_ld, n_dn;

  always #2.5 clk = ~clk;

  fault_reset_seq #(.LOAD_CYCLES(L), .STARTUP_CYCLES(S)) u_fault_reset_seq (
    .clk(clk), .rst_n(rst_n), .thermal_sd(thermal_sd), .supply_ov(supply_ov),
    .supply_uv(supply_uv), .sw_reset(sw_reset), .sev_clr(sev_clr), .flag_clr(flag_clr),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .otp_mask_in(otp_mask_in),
    .regs_off(regs_off), .gpo_low(gpo_low), .reg_reset(reg_reset), .otp_load(otp_load),
    .otp_done(otp_done), .rst_flag(rst_flag), .rst_mask(rst_mask), .irq_n(irq_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tally_clear();
    n_edges = 0; n_rr = 0; n_ld = 0; n_dn = 0;
  endtask

  task automatic wait_run();
    for (int i = 0; i < 100; i++) begin
      step();
      n_edges++;
      n_rr += int'(reg_reset);
      n_ld += int'(otp_load);
      n_dn += int'(otp_done);
      if (!regs_off) return;
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; step(); sig = 0;
  endtask

  localparam logic [4:0] VEC [6] = '{
    5'b1_0_1_01, 5'b0_1_0_01, 5'b1_0_1_10,
    5'b0_1_0_10, 5'b1_0_0_00, 5'b0_1_1_00 };

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9 reset state
    check(regs_off && gpo_low && irq_n && rst_mask && !reg_reset && !otp_load, "R9 reset outputs",
          {regs_off, gpo_low, irq_n, rst_mask, reg_reset, otp_load}, 6'b111100);
    rst_n = 1;
    tally_clear();
    wait_run();
    check(n_edges == SEQ, "R4/R9 power-up length", n_edges, SEQ);
    check(n_rr == 1 && n_dn == 1, "R4 reset and done pulses", n_rr * 10 + n_dn, 11);
    check(n_ld == L, "R4 load length", n_ld, L);
    check(rst_flag && !irq_n, "R7/R8 flag after power-up", rst_flag, 1);

    foreach (VEC[k]) begin
      pulse(flag_clr);
      check(!rst_flag && irq_n, "R7 flag clear", rst_flag, 0);
      otp_mask_in = VEC[k][3];
      mask_wdata = VEC[k][2];
      pulse(mask_wr);
      check(rst_mask == VEC[k][2], "R6 bus mask write", rst_mask, VEC[k][2]);
      tally_clear();
      case (VEC[k][1:0])
        2'd1: begin
          supply_uv = 1;
          for (int j = 0; j < 3; j++) begin
            step();
            n_rr += int'(reg_reset);
            check(regs_off && gpo_low, "R3 held off in undervoltage", regs_off, 1);
          end
          check(n_rr == 0, "R3 no register reset during undervoltage", n_rr, 0);
          supply_uv = 0;
        end
        2'd2: begin
          sw_reset = 1; step(); sw_reset = 0;
          n_edges = 1;
          check(regs_off, "R5 software reset shuts down", regs_off, 1);
        end
        default: begin
          rst_n = 0; @(negedge clk); rst_n = 1;
        end
      endcase
      wait_run();
      check(n_edges == SEQ + (VEC[k][1:0] == 2'd2 ? 1 : 0), "R4/R5 restart length",
            n_edges, SEQ + (VEC[k][1:0] == 2'd2 ? 1 : 0));
      check(rst_mask == VEC[k][3], "R6 mask reloaded from otp", rst_mask, VEC[k][3]);
      check(rst_flag == VEC[k][4] && irq_n == !VEC[k][4], "R7/R8 flag per loaded mask",
            rst_flag, VEC[k][4]);
    end

    // R5: sw_reset outside RUN ignored
    otp_mask_in = 0;
    pulse(flag_clr);
    supply_uv = 1; step(); supply_uv = 0;
    tally_clear();
    sw_reset = 1;
    for (int j = 0; j < 3; j++) begin step(); n_edges++; end
    sw_reset = 0;
    wait_run();
    check(n_edges == SEQ, "R5 sw_reset ignored outside run", n_edges, SEQ);
    pulse(flag_clr);

    // R1/R2 thermal
    thermal_sd = 1; #1;
    check(regs_off && gpo_low, "R1 thermal forces off same cycle", regs_off, 1);
    @(negedge clk); step();
    check(!irq_n, "R2/R8 severe flag interrupts", irq_n, 0);
    pulse(sev_clr);
    thermal_sd = 0; step(); step();
    check(regs_off && gpo_low && !irq_n, "R2 clear ignored while active, stays off", regs_off, 1);
    pulse(sev_clr);
    check(!regs_off && !gpo_low && irq_n, "R2 cleared after condition ends", regs_off, 0);

    // R1/R2 overvoltage
    supply_ov = 1; #1;
    check(regs_off && gpo_low, "R1 overvoltage forces off same cycle", gpo_low, 1);
    @(negedge clk); supply_ov = 0; step();
    check(regs_off, "R2 overvoltage latched", regs_off, 1);
    pulse(sev_clr);
    check(!regs_off && irq_n, "R2 overvoltage cleared", regs_off, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule